// File: doc/BRIEF.md
# DMA Channel Address and Count Generator

This block serves one channel of a dual-address DMA engine. Each completed transfer is signalled by a one-cycle advance strobe. On that strobe the block moves the source address and the destination address to their next values and counts down the remaining transfers. The source and the destination are configured separately. Each can hold its address fixed, step it up by the data size, or step it around a small ring of 2, 4, 8, 16 or 32 transfers and then return to where it started.

All address arithmetic stays inside the 64 KB bank that the base address selects. Only the low 16 bits ever move, and they wrap within the bank. A load command copies the base addresses and the reload count into the working registers and arms the channel. A reload value of N allows N+1 transfers. The advance that finds the count at zero raises a one-cycle underflow pulse, which serves as the channel's interrupt request and cascade trigger. The same advance sets a terminal flag, and the channel then ignores advance strobes until the next load.

Top module: `dma_addr_count_gen`

## Requirements
- R1: A load copies the source and destination base addresses into the address outputs and the reload value into the count, and clears the terminal flag, all visible one cycle later. A load in the same cycle as an advance wins, and that advance has no effect.
- R2: Mode code 2'b00 (fixed) leaves the address unchanged on every advance. The reserved code 2'b11 behaves the same way.
- R3: Mode code 2'b01 (increment) adds 1 to the address per advance when the size input is 0 (8-bit data), and adds 2 when it is 1 (16-bit data).
- R4: Address bits 23:16 never change on an advance. Bits 15:0 wrap modulo 65536.
- R5: Mode code 2'b10 (ring) steps like increment mode. After 2^(k+1) advances the address is back at its loaded value, where k is the 3-bit ring select clamped to at most 4 (codes 5 to 7 give 32 transfers).
- R6: With a reload value of N, the (N+1)-th accepted advance produces a single-cycle underflow pulse in the cycle after that advance. No other advance produces one.
- R7: The terminal flag rises together with the underflow pulse and stays high until the next load.
- R8: While the terminal flag is high, advances change neither address and produce no underflow. This includes the idle state after reset.
- R9: The source and destination mode, ring select and base are applied independently. Both addresses move on the same advance, and the single size input sets the step for both.
- R10: After reset both addresses are zero, underflow is low and the terminal flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Arm the channel: copy bases and reload count |
| advance | input | 1 | One transfer completed |
| src_mode | input | 2 | Source addressing: 00 fixed, 01 increment, 10 ring, 11 fixed |
| dst_mode | input | 2 | Destination addressing, same encoding |
| src_ring_sel | input | 3 | Source ring length 2^(k+1), clamped to 32 |
| dst_ring_sel | input | 3 | Destination ring length select |
| wide | input | 1 | 1 = 16-bit data (step 2), 0 = 8-bit data (step 1) |
| src_base | input | 24 | Source start address |
| dst_base | input | 24 | Destination start address |
| count_reload | input | 16 | Transfers minus one |
| src_addr | output | 24 | Current source address |
| dst_addr | output | 24 | Current destination address |
| underflow | output | 1 | One-cycle pulse when the count underflows |
| done | output | 1 | Terminal flag, channel idle |

## Verification
Two things can land on one clock edge: a ring side wrapping back to its start, and the count underflowing. The sweep sizes the reload so that the final advance is also a ring wrap. That edge is judged by checking, in the same sample, that the address is back at its base, that the pulse is high and that the terminal flag has risen. A load asserted together with an advance is the second collision. The check there is that the bases and a cleared terminal flag appear, with no step applied on top. Low addresses near 0xFFFF show that the wrap stays inside the bank.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
    typedef enum logic [1:0] {
        AM_FIXED = 2'b00,
        AM_INCR  = 2'b01,
        AM_RING  = 2'b10,
        AM_RSVD  = 2'b11
    } addr_mode_e;
endpackage

// File: rtl/dmag_addr_side.sv
module dmag_addr_side
    import dmag_pkg::*;
#(
    parameter int ADDR_W        = 24,
    parameter int BANK_W        = 16,
    parameter int RING_SEL_W    = 3,
    parameter int RING_MAX_LOG2 = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  step,
    input  logic [1:0]            mode,
    input  logic [RING_SEL_W-1:0] ring_sel,
    input  logic                  wide,
    input  logic [ADDR_W-1:0]     base,
    output logic [ADDR_W-1:0]     addr
);
    localparam int IDX_W = RING_MAX_LOG2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] start_lo;
        logic [IDX_W-1:0]  idx;
    } side_t;

    side_t             s_d, s_q;
    logic [BANK_W-1:0] stride;
    logic [BANK_W-1:0] lo_next;
    logic [IDX_W-1:0]  ring_last;
    int                sel_c;

    always_comb begin
        stride    = wide ? BANK_W'(2) : BANK_W'(1);
        lo_next   = s_q.addr[BANK_W-1:0] + stride;
        sel_c     = (int'(ring_sel) > RING_MAX_LOG2 - 1) ? RING_MAX_LOG2 - 1 : int'(ring_sel);
        ring_last = IDX_W'((32'd1 << (sel_c + 1)) - 32'd1);
        s_d       = s_q;
        if (load) begin
            s_d.addr     = base;
            s_d.start_lo = base[BANK_W-1:0];
            s_d.idx      = '0;
        end else if (step) begin
            case (addr_mode_e'(mode))
                AM_INCR: s_d.addr[BANK_W-1:0] = lo_next;
                AM_RING: begin
                    if (s_q.idx == ring_last) begin
                        s_d.addr[BANK_W-1:0] = s_q.start_lo;
                        s_d.idx              = '0;
                    end else begin
                        s_d.addr[BANK_W-1:0] = lo_next;
                        s_d.idx              = s_q.idx + IDX_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr = s_q.addr;

    assert_fixed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && (mode == AM_FIXED || mode == AM_RSVD)) |=> (addr == $past(addr)));

    assert_incr_stride_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && mode == AM_INCR) |=>
        (addr[BANK_W-1:0] == BANK_W'($past(addr[BANK_W-1:0]) + ($past(wide) ? 2 : 1))));

    assert_bank_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (addr[ADDR_W-1:BANK_W] == $past(addr[ADDR_W-1:BANK_W])));
endmodule

// File: rtl/dmag_count_unit.sv
module dmag_count_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] reload,
    output logic             underflow,
    output logic             done
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             done;
        logic             uflow;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.uflow = 1'b0;
        if (load) begin
            c_d.count = reload;
            c_d.done  = 1'b0;
        end else if (step && !c_q.done) begin
            if (c_q.count == '0) begin
                c_d.uflow = 1'b1;
                c_d.done  = 1'b1;
            end else begin
                c_d.count = c_q.count - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{count: '0, done: 1'b1, uflow: 1'b0};
        else        c_q <= c_d;
    end

    assign underflow = c_q.uflow;
    assign done      = c_q.done;

    assert_uflow_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> !underflow);

    assert_uflow_sets_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> done);

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);

    assert_quiet_when_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> !underflow);
endmodule

// File: rtl/dma_addr_count_gen.sv
module dma_addr_count_gen #(
    parameter int ADDR_W        = 24,
    parameter int BANK_W        = 16,
    parameter int CNT_W         = 16,
    parameter int RING_SEL_W    = 3,
    parameter int RING_MAX_LOG2 = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  advance,
    input  logic [1:0]            src_mode,
    input  logic [1:0]            dst_mode,
    input  logic [RING_SEL_W-1:0] src_ring_sel,
    input  logic [RING_SEL_W-1:0] dst_ring_sel,
    input  logic                  wide,
    input  logic [ADDR_W-1:0]     src_base,
    input  logic [ADDR_W-1:0]     dst_base,
    input  logic [CNT_W-1:0]      count_reload,
    output logic [ADDR_W-1:0]     src_addr,
    output logic [ADDR_W-1:0]     dst_addr,
    output logic                  underflow,
    output logic                  done
);
    logic step_go;

    assign step_go = advance && !done && !load;

    dmag_addr_side #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W),
        .RING_SEL_W(RING_SEL_W), .RING_MAX_LOG2(RING_MAX_LOG2)
    ) src_side_i (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step_go),
        .mode(src_mode), .ring_sel(src_ring_sel), .wide(wide),
        .base(src_base), .addr(src_addr)
    );

    dmag_addr_side #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W),
        .RING_SEL_W(RING_SEL_W), .RING_MAX_LOG2(RING_MAX_LOG2)
    ) dst_side_i (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step_go),
        .mode(dst_mode), .ring_sel(dst_ring_sel), .wide(wide),
        .base(dst_base), .addr(dst_addr)
    );

    dmag_count_unit #(.CNT_W(CNT_W)) count_i (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step_go),
        .reload(count_reload), .underflow(underflow), .done(done)
    );

    assert_load_restores_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (src_addr == $past(src_base) && dst_addr == $past(dst_base) && !done));

    assert_idle_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> ($stable(src_addr) && $stable(dst_addr)));
endmodule

// File: tb/dma_addr_count_gen_tb.sv
`timescale 1ns/1ps
module dma_addr_count_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic        advance = 1'b0;
    logic [1:0]  src_mode = '0, dst_mode = '0;
    logic [2:0]  src_ring_sel = '0, dst_ring_sel = '0;
    logic        wide = 1'b0;
    logic [23:0] src_base = '0, dst_base = '0;
    logic [15:0] count_reload = '0;
    logic [23:0] src_addr, dst_addr;
    logic        underflow, done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dma_addr_count_gen dut_i (
        .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
        .src_mode(src_mode), .dst_mode(dst_mode),
        .src_ring_sel(src_ring_sel), .dst_ring_sel(dst_ring_sel),
        .wide(wide), .src_base(src_base), .dst_base(dst_base),
        .count_reload(count_reload), .src_addr(src_addr), .dst_addr(dst_addr),
        .underflow(underflow), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_addr(input logic [1:0] m, input logic [2:0] sel,
                                              input logic w, input logic [23:0] b, input int k);
        int step = w ? 2 : 1;
        int sc = (sel > 3'd4) ? 4 : int'(sel);
        int len = 2 << sc;
        int off;
        logic [15:0] lo;
        case (m)
            2'b01:   off = k * step;
            2'b10:   off = (k % len) * step;
            default: off = 0;
        endcase
        lo = b[15:0] + off[15:0];
        return {b[23:16], lo};
    endfunction

    task automatic run_case(input logic [1:0] sm, input logic [2:0] ss,
                            input logic [1:0] dm, input logic [2:0] ds, input logic w,
                            input logic [23:0] sb, input logic [23:0] db,
                            input int n, input int extra);
        int ke;
        @(negedge clk);
        src_mode = sm; dst_mode = dm; src_ring_sel = ss; dst_ring_sel = ds;
        wide = w; src_base = sb; dst_base = db; count_reload = n[15:0];
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk("R1 load src", {8'h0, src_addr}, {8'h0, sb});
        chk("R1 load dst", {8'h0, dst_addr}, {8'h0, db});
        chk("R1 done cleared", {31'h0, done}, 32'h0);
        for (int k = 1; k <= n + 1 + extra; k++) begin
            advance = 1'b1;
            @(negedge clk);
            advance = 1'b0;
            ke = (k > n + 1) ? n + 1 : k;
            chk("R2/R3/R4/R5/R9 src", {8'h0, src_addr}, {8'h0, exp_addr(sm, ss, w, sb, ke)});
            chk("R2/R3/R4/R5/R9 dst", {8'h0, dst_addr}, {8'h0, exp_addr(dm, ds, w, db, ke)});
            chk("R6/R8 underflow", {31'h0, underflow}, {31'h0, (k == n + 1)});
            chk("R7 done", {31'h0, done}, {31'h0, (k >= n + 1)});
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 src reset", {8'h0, src_addr}, 32'h0);
        chk("R10 dst reset", {8'h0, dst_addr}, 32'h0);
        chk("R10 underflow reset", {31'h0, underflow}, 32'h0);
        chk("R10 done reset", {31'h0, done}, 32'h1);

        // R8: advance before any load is ignored
        src_mode = 2'b01; dst_mode = 2'b01; src_base = 24'h111111;
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        chk("R8 idle src", {8'h0, src_addr}, 32'h0);
        chk("R8 idle underflow", {31'h0, underflow}, 32'h0);

        // sweep of modes, ring lengths, sizes; ring count chosen so last advance is a wrap
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 6; s++)
                for (int w = 0; w < 2; w++) begin
                    int sc;
                    int n;
                    if (m != 2 && s > 0) continue;
                    sc = (s > 4) ? 4 : s;
                    n  = (m == 2) ? ((2 << sc) * 2 - 1) : 9;
                    run_case(m[1:0], s[2:0], 2'((m + 1) % 4), 3'(5 - s), w[0],
                             {8'h10 + 8'(m), 16'h1000 + 16'(s * 64)},
                             {8'h80 + 8'(s), 16'h2000 + 16'(m * 32)}, n, 2);
                end

        // R4: bank wrap in increment and ring mode
        run_case(2'b01, 3'd0, 2'b01, 3'd0, 1'b1, 24'h34FFFE, 24'h56FFFF, 3, 1);
        run_case(2'b10, 3'd1, 2'b01, 3'd0, 1'b0, 24'h7AFFFE, 24'hC0FFFD, 5, 1);
        // R6: reload of zero gives one transfer; longer count
        run_case(2'b01, 3'd0, 2'b00, 3'd0, 1'b0, 24'h001234, 24'h00ABCD, 0, 3);
        run_case(2'b01, 3'd0, 2'b10, 3'd7, 1'b1, 24'h020000, 24'h030100, 300, 2);

        // R1: load and advance in the same cycle
        @(negedge clk);
        src_mode = 2'b01; dst_mode = 2'b01; wide = 1'b0;
        src_base = 24'h440010; dst_base = 24'h550020; count_reload = 16'd5;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        advance = 1'b1;
        repeat (2) @(negedge clk);
        src_base = 24'h660100; dst_base = 24'h770200;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0; advance = 1'b0;
        chk("R1 load wins src", {8'h0, src_addr}, 32'h00660100);
        chk("R1 load wins dst", {8'h0, dst_addr}, 32'h00770200);
        chk("R1 load wins done", {31'h0, done}, 32'h0);
        chk("R1 load wins underflow", {31'h0, underflow}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule